// File: doc/BRIEF.md
# Ordered Store Buffer with Consistency Modes and Fences

This block sits between an in-order core's load/store issue port and a single-ported memory. Stores are accepted into a four-entry buffer and written to memory later. Loads are held in a one-load slot. Each load is answered either from the youngest buffered store to its address or by a read from memory. How far a load may run ahead of buffered stores, and the order in which buffered stores drain, depend on a consistency mode sampled while reset is asserted. There are three modes: sequential, total-store-order and partial-store-order.

The issue port also accepts three fence operations. A fence is held on the port (ready low) until its ordering condition holds, and is accepted only then. Because of this, no later operation can issue before the condition is met. The memory side is a request/ready port with at most one transaction in flight. A write completes at its handshake. A read completes when its single `mem_rvalid` pulse arrives. Memory samples the request only in the handshake cycle.

Top module: `sb_order_buf`

## Requirements
- R1: `mode_i` is captured only while `rst_n` is low (0 = sequential, 1 = total-store-order, 2 = partial-store-order, 3 behaves as sequential). Changing it afterwards has no effect on ordering.
- R2: In sequential mode, a load that misses the buffer is requested from memory only when the buffer holds no stores.
- R3: In total-store-order and partial-store-order modes, a load whose address matches no buffered store is requested from memory while older stores are still buffered.
- R4: In sequential and total-store-order modes, buffered stores are written to memory in the order they were issued.
- R5: In partial-store-order mode, the next store drained is the youngest buffered entry that has no older buffered entry to the same address.
- R6: In every mode, two stores to the same address are written to memory in issue order.
- R7: A load whose address matches buffered stores returns the data of the youngest matching store on `rsp_data`, with a one-cycle `rsp_valid` pulse, and makes no memory read.
- R8: With four stores buffered, `iss_ready` is low for a store operation (`iss_op` = 1) until an entry drains.
- R9: A write fence (`iss_op` = 3) or full fence (`iss_op` = 4) is accepted only when the buffer is empty, so every earlier store has already been written.
- R10: A read fence (`iss_op` = 2) is accepted as soon as no load is outstanding, even with stores buffered. Loads use `iss_op` = 0.
- R11: After a read handshake, no memory request is raised until the matching `mem_rvalid` arrives.
- R12: After reset, `mem_req` and `rsp_valid` are low and a store is ready to be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; mode is sampled while low |
| mode_i | input | 2 | Consistency mode selection |
| iss_valid | input | 1 | Issue operation valid |
| iss_ready | output | 1 | Issue operation accepted this cycle when valid |
| iss_op | input | 3 | 0 load, 1 store, 2 read fence, 3 write fence, 4 full fence |
| iss_addr | input | AW | Word address of load or store |
| iss_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Load data valid pulse |
| rsp_data | output | DW | Load data |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | DW | Read data |

## Verification
The bench holds memory writes back while reads still go through. This separates a sequential load, which must wait for the drain and would return early if the mode check were wrong, from a total-store-order load, which must pass the buffer and would hang if bypass were missing. It builds a buffer with two stores to one address around a store to another, then checks the drain log in both store-ordering modes. A wrong skip rule would write the younger same-address value first, and a wrong pointer would mix up the orders. Fences are held against a non-empty buffer, where a write or full fence accepted early would let later work overtake stores. A forwarding mux that picks the oldest match returns stale data. A full-buffer check catches an overwritten entry, and changing the mode after reset catches a mode that is not latched.

// File: rtl/sb_order_buf.sv
module sb_order_buf #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          iss_valid,
  output logic          iss_ready,
  input  logic [2:0]    iss_op,
  input  logic [AW-1:0] iss_addr,
  input  logic [DW-1:0] iss_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_RF = 3'd2, OP_WF = 3'd3, OP_FF = 3'd4;
  localparam logic [1:0] M_TSO = 2'd1, M_PSO = 2'd2;

  logic [1:0]    mode_q;
  logic [AW-1:0] ea [DEPTH];
  logic [DW-1:0] ed [DEPTH];
  logic [AW-1:0] na [DEPTH];
  logic [DW-1:0] nd [DEPTH];
  logic [CW-1:0] cnt, ncnt;
  logic          ld_busy, ld_sent;
  logic [AW-1:0] ld_addr;
  logic          fwd_hit, blk;
  logic [DW-1:0] fwd_data;
  logic [IW-1:0] pso_sel, sel;
  logic          load_wants, drain_wants, mem_fire, st_done, iss_fire, push, ld_take;

  wire buf_empty = (cnt == '0);
  wire relaxed   = (mode_q == M_TSO) || (mode_q == M_PSO);

  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) < cnt && ea[i] == ld_addr) begin
        fwd_hit  = 1'b1;
        fwd_data = ed[i];
      end
  end

  always_comb begin
    pso_sel = '0;
    blk     = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) < cnt) begin
        blk = 1'b0;
        for (int j = 0; j < DEPTH; j++)
          if (j < i && ea[j] == ea[i]) blk = 1'b1;
        if (!blk) pso_sel = IW'(i);
      end
  end

  assign sel         = (mode_q == M_PSO) ? pso_sel : '0;
  assign load_wants  = ld_busy && !ld_sent && !fwd_hit && (buf_empty || relaxed);
  assign drain_wants = !buf_empty && !ld_sent && !load_wants;
  assign mem_req     = load_wants || drain_wants;
  assign mem_we      = !load_wants;
  assign mem_addr    = load_wants ? ld_addr : ea[sel];
  assign mem_wdata   = ed[sel];
  assign mem_fire    = mem_req && mem_ready;
  assign st_done     = mem_fire && mem_we;

  always_comb begin
    case (iss_op)
      OP_LD, OP_RF: iss_ready = !ld_busy;
      OP_ST:        iss_ready = !ld_busy && (cnt < CW'(DEPTH));
      OP_WF, OP_FF: iss_ready = !ld_busy && buf_empty;
      default:      iss_ready = 1'b0;
    endcase
  end

  assign iss_fire = iss_valid && iss_ready;
  assign push     = iss_fire && (iss_op == OP_ST);
  assign ld_take  = iss_fire && (iss_op == OP_LD);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      na[i] = ea[i];
      nd[i] = ed[i];
    end
    for (int i = 0; i < DEPTH - 1; i++)
      if (st_done && i >= int'(sel)) begin
        na[i] = ea[i+1];
        nd[i] = ed[i+1];
      end
    ncnt = cnt - CW'(st_done);
    if (push) begin
      na[ncnt[IW-1:0]] = iss_addr;
      nd[ncnt[IW-1:0]] = iss_wdata;
    end
    ncnt = ncnt + CW'(push);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      ea[i] <= na[i];
      ed[i] <= nd[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= mode_i;
      cnt       <= '0;
      ld_busy   <= 1'b0;
      ld_sent   <= 1'b0;
      ld_addr   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      cnt       <= ncnt;
      rsp_valid <= 1'b0;
      if (ld_take) begin
        ld_busy <= 1'b1;
        ld_sent <= 1'b0;
        ld_addr <= iss_addr;
      end
      if (ld_busy && !ld_sent && fwd_hit) begin
        rsp_valid <= 1'b1;
        rsp_data  <= fwd_data;
        ld_busy   <= 1'b0;
      end
      if (mem_fire && !mem_we) ld_sent <= 1'b1;
      if (ld_sent && mem_rvalid) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem_rdata;
        ld_busy   <= 1'b0;
        ld_sent   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sb_order_chk.sv
module sb_order_chk #(
  parameter int DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_q,
  input logic [CW-1:0] cnt,
  input logic          iss_valid,
  input logic          iss_ready,
  input logic [2:0]    iss_op,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic          mem_rvalid
);
  logic rd_out;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_out <= 1'b0;
    else if (mem_req && mem_ready && !mem_we) rd_out <= 1'b1;
    else if (mem_rvalid) rd_out <= 1'b0;
  end

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $stable(mode_q));
  // R2
  sc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd1 && mode_q != 2'd2 && mem_req && !mem_we) |-> cnt == '0);
  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && iss_valid && iss_op == 3'd1) |-> !iss_ready);
  // R9
  wfence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && (iss_op == 3'd3 || iss_op == 3'd4)) |-> cnt == '0);
  // R11
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_out |-> !mem_req);
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
endmodule

bind sb_order_buf sb_order_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .cnt(cnt),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we), .mem_rvalid(mem_rvalid)
);

// File: tb/tb_sb_order_buf.sv
`timescale 1ns/1ps
module tb_sb_order_buf;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_i = 0;
  logic iss_valid = 0, iss_ready;
  logic [2:0] iss_op = 0;
  logic [15:0] iss_addr = 0;
  logic [31:0] iss_wdata = 0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic mem_req, mem_ready, mem_we, mem_rvalid;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic blk_wr = 0, mem_clr = 1, rv_pend;
  logic [15:0] rv_addr;
  logic [31:0] mem [16];
  logic [15:0] wla [16];
  logic [31:0] wld [16];
  logic [4:0] wn;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sb_order_buf dut (.clk(clk), .rst_n(rst_n), .mode_i(mode_i), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_op(iss_op), .iss_addr(iss_addr), .iss_wdata(iss_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata));

  assign mem_ready = !(blk_wr && mem_we);

  always @(posedge clk) begin
    if (mem_clr) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'hA000_0000 + i;
      wn <= 0; rv_pend <= 0; mem_rvalid <= 0; mem_rdata <= 0; rv_addr <= 0;
    end else begin
      mem_rvalid <= 0;
      if (rv_pend) begin mem_rvalid <= 1; mem_rdata <= mem[rv_addr[3:0]]; rv_pend <= 0; end
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr[3:0]] <= mem_wdata;
          wla[wn[3:0]] <= mem_addr; wld[wn[3:0]] <= mem_wdata; wn <= wn + 1;
        end else begin rv_pend <= 1; rv_addr <= mem_addr; end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 0; mem_clr = 1; mode_i = m; blk_wr = 0; iss_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; mem_clr = 0;
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    iss_valid = 1; iss_op = op; iss_addr = a; iss_wdata = d;
    while (!iss_ready) @(negedge clk);
    @(posedge clk);
    #1 iss_valid = 0;
  endtask

  task automatic wait_rsp(output logic got, output logic [31:0] d, output logic [4:0] nw);
    got = 0; d = 0; nw = 0;
    for (int k = 0; k < 60 && !got; k++) begin
      @(negedge clk);
      if (rsp_valid) begin got = 1; d = rsp_data; nw = wn; end
    end
  endtask

  task automatic wait_writes(input int n);
    for (int k = 0; k < 60 && wn < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(2'd0);
    iss_op = 3'd1;
    #0;
    chk("R12 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R12 store ready", {31'd0, iss_ready}, 32'd1);
  endtask

  task automatic t_sc_wait;
    logic got; logic [31:0] d; logic [4:0] nw; int seen;
    do_reset(2'd0);
    blk_wr = 1;
    issue(3'd1, 16'd1, 32'h55);
    issue(3'd0, 16'd2, 0);
    seen = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (rsp_valid) seen++; end
    chk("R2 no early load", seen, 0);
    blk_wr = 0;
    wait_rsp(got, d, nw);
    chk("R2 load returned", {31'd0, got}, 32'd1);
    chk("R2 load data", d, 32'hA000_0002);
    chk("R2 store drained first", {27'd0, nw}, 32'd1);
  endtask

  task automatic t_tso_bypass(input logic [1:0] later_mode, input string tag);
    logic got; logic [31:0] d; logic [4:0] nw;
    do_reset(2'd1);
    mode_i = later_mode;
    blk_wr = 1;
    issue(3'd1, 16'd1, 32'h66);
    issue(3'd0, 16'd2, 0);
    wait_rsp(got, d, nw);
    chk({tag, " bypass returned"}, {31'd0, got}, 32'd1);
    chk({tag, " bypass data"}, d, 32'hA000_0002);
    chk({tag, " store still buffered"}, {27'd0, nw}, 32'd0);
    blk_wr = 0;
    wait_writes(1);
  endtask

  task automatic t_forward;
    logic got; logic [31:0] d; logic [4:0] nw;
    do_reset(2'd1);
    blk_wr = 1;
    issue(3'd1, 16'd4, 32'h11);
    issue(3'd1, 16'd4, 32'h22);
    issue(3'd1, 16'd7, 32'h33);
    issue(3'd0, 16'd4, 0);
    wait_rsp(got, d, nw);
    chk("R7 forwarded", {31'd0, got}, 32'd1);
    chk("R7 youngest data", d, 32'h22);
    chk("R7 no memory write", {27'd0, nw}, 32'd0);
    @(negedge clk);
    chk("R7 no memory read", {31'd0, mem_rvalid}, 32'd0);
    blk_wr = 0;
    wait_writes(3);
  endtask

  task automatic t_order(input logic [1:0] m);
    do_reset(m);
    blk_wr = 1;
    issue(3'd1, 16'd5, 32'h1);
    issue(3'd1, 16'd6, 32'h2);
    issue(3'd1, 16'd5, 32'h3);
    blk_wr = 0;
    wait_writes(3);
    chk("R6 count", {27'd0, wn}, 32'd3);
    if (m == 2'd2) begin
      chk("R5 first addr", {16'd0, wla[0]}, 32'd6);
      chk("R5 second data", wld[1], 32'h1);
      chk("R6 pso last data", wld[2], 32'h3);
    end else begin
      chk("R4 first data", wld[0], 32'h1);
      chk("R4 second addr", {16'd0, wla[1]}, 32'd6);
      chk("R6 tso last data", wld[2], 32'h3);
    end
  endtask

  task automatic t_full;
    do_reset(2'd1);
    blk_wr = 1;
    for (int i = 0; i < 4; i++) issue(3'd1, 16'(8 + i), 32'(i + 100));
    @(negedge clk);
    iss_valid = 1; iss_op = 3'd1; iss_addr = 16'd12; iss_wdata = 32'd104;
    #0;
    chk("R8 full stall", {31'd0, iss_ready}, 32'd0);
    @(negedge clk);
    chk("R8 still stalled", {31'd0, iss_ready}, 32'd0);
    iss_valid = 0;
    blk_wr = 0;
    issue(3'd1, 16'd12, 32'd104);
    wait_writes(5);
    chk("R8 no entry lost", {27'd0, wn}, 32'd5);
    chk("R4 full order", {16'd0, wla[4]}, 32'd12);
    chk("R8 first entry intact", wld[0], 32'd100);
  endtask

  task automatic t_fence(input logic [2:0] op, input string tag);
    do_reset(2'd2);
    blk_wr = 1;
    issue(3'd1, 16'd3, 32'h77);
    @(negedge clk);
    iss_valid = 1; iss_op = op; iss_addr = 0;
    #0;
    chk({tag, " fence held"}, {31'd0, iss_ready}, 32'd0);
    @(negedge clk);
    chk({tag, " fence still held"}, {31'd0, iss_ready}, 32'd0);
    iss_valid = 0;
    blk_wr = 0;
    issue(op, 16'd0, 0);
    chk({tag, " store done before fence"}, {27'd0, wn}, 32'd1);
  endtask

  task automatic t_rfence;
    do_reset(2'd1);
    blk_wr = 1;
    issue(3'd1, 16'd3, 32'h88);
    @(negedge clk);
    iss_valid = 1; iss_op = 3'd2;
    #0;
    chk("R10 read fence ready", {31'd0, iss_ready}, 32'd1);
    chk("R10 store still buffered", {27'd0, wn}, 32'd0);
    iss_valid = 0;
    blk_wr = 0;
    wait_writes(1);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_sc_wait();
    t_tso_bypass(2'd1, "R3");
    t_tso_bypass(2'd0, "R1");
    t_forward();
    t_order(2'd1);
    t_order(2'd0);
    t_order(2'd2);
    t_full();
    t_fence(3'd3, "R9 write");
    t_fence(3'd4, "R9 full");
    t_rfence();
    finish_up();
  end
endmodule